// File: doc/BRIEF.md
# Crosswise 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns their 8-bit product in the same cycle. It has no clock and no state. The operands are cut into 2-bit slices. Four small 2x2 multipliers form the four slice-by-slice partial products in parallel, using the vertical-and-crosswise method. A tree of three generate/propagate lookahead adders then combines them. The tree has one 4-bit adder and two 6-bit adders. Every carry in each adder is computed as a flat sum-of-products over the generate and propagate terms below it, so no carry ripples from bit to bit.

The two least significant product bits come from the low-slice partial product and take no adder at all. The 4-bit adder aligns the upper half of the low-slice product with the high-A/low-B product. The first 6-bit adder places the high-slice product two bits above the low-A/high-B product and adds them. The final 6-bit adder adds the two intermediate sums and forms product bits 7 to 2.

Top module: `crosswise_mul4`

## Requirements
- R1: For every pair of operands, `prod` equals the arithmetic product `mul_a * mul_b` as an 8-bit unsigned value.
- R2: `prod[1:0]` equals the low two bits of `mul_a[1:0] * mul_b[1:0]` and depends on no other operand bit.
- R3: When `mul_a[3:2]` and `mul_b[3:2]` are both zero, `prod` equals the 2x2 slice product `mul_a[1:0] * mul_b[1:0]`, with the upper four bits zero.
- R4: If either operand is zero, `prod` is zero.
- R5: `mul_a` = 4'b1111 with `mul_b` = 4'b1010 gives `prod` = 8'b10010110.
- R6: If either operand is 4'b0001, `prod` equals the other operand zero-extended to 8 bits.
- R7: Both operands at 4'b1111 give the largest product, 8'd225. The carry-out of each of the three merge adders stays zero for every operand pair, so dropping the final carry loses nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_a | input | 4 | Multiplicand, unsigned |
| mul_b | input | 4 | Multiplier, unsigned |
| prod | output | 8 | Unsigned product |

## Verification
Every result of this block is purely combinational. Each product bit is therefore due in the cycle its operands are applied, zero clock edges later. The bench drives a new operand pair just after a rising edge of its sampling clock. It reads `prod` half a period later, on the falling edge, so the adder tree has settled and no check races the edge. The sweep covers all 256 operand pairs. The slice, zero, identity and all-ones cases are each checked against their own arithmetic expectation.

// File: rtl/crosswise_pkg.sv
package crosswise_pkg;
    localparam int OPW   = 4;
    localparam int SLW   = OPW / 2;
    localparam int PRODW = 2 * OPW;
    localparam int PPW   = 2 * SLW;
    localparam int MIDW  = PPW;
    localparam int TOPW  = PRODW - SLW;

    typedef logic [OPW-1:0]   operand_t;
    typedef logic [SLW-1:0]   slice_t;
    typedef logic [PPW-1:0]   pp_t;
    typedef logic [PRODW-1:0] product_t;

    typedef struct packed {
        pp_t hh;
        pp_t lh;
        pp_t hl;
        pp_t ll;
    } pp_set_t;

    typedef struct packed {
        logic carry;
        logic sum;
    } ha_t;

    function automatic ha_t half_add(input logic x, input logic y);
        ha_t r;
        r.sum   = x ^ y;
        r.carry = x & y;
        return r;
    endfunction
endpackage

// File: rtl/slice_mul2.sv
module slice_mul2
    import crosswise_pkg::*;
(
    input  slice_t x,
    input  slice_t y,
    output pp_t    p
);
    ha_t cross_ha;
    ha_t top_ha;

    always_comb begin
        cross_ha = half_add(x[1] & y[0], x[0] & y[1]);
        top_ha   = half_add(x[1] & y[1], cross_ha.carry);
        p        = {top_ha.carry, top_ha.sum, cross_ha.sum, x[0] & y[0]};
    end
endmodule

// File: rtl/gp_lookahead_add.sv
module gp_lookahead_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W-1:0] gen;
    logic [W-1:0] prp;
    logic [W:0]   cy;

    assign gen = x & y;
    assign prp = x ^ y;

    always_comb begin
        logic term;
        logic chain;
        cy[0] = cin;
        for (int i = 0; i < W; i++) begin
            term  = gen[i];
            chain = prp[i];
            for (int j = i - 1; j >= 0; j--) begin
                term  = term | (chain & gen[j]);
                chain = chain & prp[j];
            end
            cy[i+1] = term | (chain & cin);
        end
    end

    assign s    = prp ^ cy[W-1:0];
    assign cout = cy[W];
endmodule

// File: rtl/crosswise_mul4.sv
module crosswise_mul4
    import crosswise_pkg::*;
(
    input  logic [3:0] mul_a,
    input  logic [3:0] mul_b,
    output logic [7:0] prod
);
    pp_set_t            pp;
    logic [MIDW-1:0]    mid_sum;
    logic [TOPW-1:0]    hi_sum;
    logic [TOPW-1:0]    fin_sum;
    logic               mid_cout;
    logic               hi_cout;
    logic               fin_cout;

    slice_mul2 u_ll (.x(mul_a[SLW-1:0]),   .y(mul_b[SLW-1:0]),   .p(pp.ll));
    slice_mul2 u_hl (.x(mul_a[OPW-1:SLW]), .y(mul_b[SLW-1:0]),   .p(pp.hl));
    slice_mul2 u_lh (.x(mul_a[SLW-1:0]),   .y(mul_b[OPW-1:SLW]), .p(pp.lh));
    slice_mul2 u_hh (.x(mul_a[OPW-1:SLW]), .y(mul_b[OPW-1:SLW]), .p(pp.hh));

    gp_lookahead_add #(.W(MIDW)) u_mid (
        .x    ({{(MIDW-SLW){1'b0}}, pp.ll[PPW-1:SLW]}),
        .y    (pp.hl),
        .cin  (1'b0),
        .s    (mid_sum),
        .cout (mid_cout)
    );

    gp_lookahead_add #(.W(TOPW)) u_hi (
        .x    ({pp.hh, {SLW{1'b0}}}),
        .y    ({{(TOPW-PPW){1'b0}}, pp.lh}),
        .cin  (1'b0),
        .s    (hi_sum),
        .cout (hi_cout)
    );

    gp_lookahead_add #(.W(TOPW)) u_fin (
        .x    (hi_sum),
        .y    ({{(TOPW-MIDW){1'b0}}, mid_sum}),
        .cin  (1'b0),
        .s    (fin_sum),
        .cout (fin_cout)
    );

    assign prod = {fin_sum, pp.ll[SLW-1:0]};
endmodule

// File: rtl/crosswise_mul4_chk.sv
module crosswise_mul4_chk (
    input logic [3:0] mul_a,
    input logic [3:0] mul_b,
    input logic [7:0] prod,
    input logic       c_mid,
    input logic       c_hi,
    input logic       c_fin
);
    logic [7:0] ref_prod;
    logic [3:0] ref_low;

    always_comb begin
        ref_prod = {4'b0, mul_a} * {4'b0, mul_b};
        ref_low  = {2'b0, mul_a[1:0]} * {2'b0, mul_b[1:0]};
        // R1
        product_match_chk: assert (prod == ref_prod)
            else $error("R1 product %0d for %0d*%0d", prod, mul_a, mul_b);
        // R2
        low_pass_chk: assert (prod[1:0] == ref_low[1:0])
            else $error("R2 low bits %b", prod[1:0]);
        // R4
        zero_operand_chk: assert (!(mul_a == 4'd0 || mul_b == 4'd0) || prod == 8'd0)
            else $error("R4 nonzero product %0d", prod);
        // R6
        identity_chk: assert (!(mul_b == 4'd1) || prod == {4'b0, mul_a})
            else $error("R6 identity product %0d", prod);
        // R7
        no_overflow_chk: assert (!c_mid && !c_hi && !c_fin)
            else $error("R7 adder carry-out set");
    end
endmodule

bind crosswise_mul4 crosswise_mul4_chk u_chk (
    .mul_a (mul_a),
    .mul_b (mul_b),
    .prod  (prod),
    .c_mid (mid_cout),
    .c_hi  (hi_cout),
    .c_fin (fin_cout)
);

// File: tb/tb_crosswise_mul4.sv
module tb_crosswise_mul4;
    logic       clk = 1'b0;
    logic [3:0] a;
    logic [3:0] b;
    logic [7:0] q;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    crosswise_mul4 dut (.mul_a(a), .mul_b(b), .prod(q));

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, got, exp);
        end
    endtask

    task automatic apply(input int x, input int y);
        @(posedge clk);
        #0.5;
        a = 4'(x);
        b = 4'(y);
        @(negedge clk);
    endtask

    initial begin
        for (int n = 0; n < 20000; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        a = 4'd0;
        b = 4'd0;
        @(negedge clk);
        // R4: idle operands read as zero product
        check("R4 initial", int'(q), 0);

        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                apply(x, y);
                // R1: full product
                check("R1 sweep", int'(q), x * y);
                // R2: low two bits from low slices only
                check("R2 low bits", int'(q[1:0]), ((x % 4) * (y % 4)) % 4);
                // R3: upper slices zero gives slice product
                if (x < 4 && y < 4)
                    check("R3 slice product", int'(q), (x % 4) * (y % 4));
                // R4: zero operand
                if (x == 0 || y == 0)
                    check("R4 zero operand", int'(q), 0);
                // R6: multiply by one
                if (y == 1) check("R6 identity b", int'(q), x);
                if (x == 1) check("R6 identity a", int'(q), y);
            end
        end

        apply(15, 10);
        check("R5 pattern", int'(q), 8'b10010110);
        apply(10, 15);
        check("R5 swapped", int'(q), 150);
        apply(15, 15);
        check("R7 max", int'(q), 225);
        apply(12, 12);
        check("R7 high slices", int'(q), 144);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule